// File: doc/BRIEF.md
# SSIF Response Read Segmenter

This block holds one IPMI response message of up to 255 bytes. It hands that message to an SMBus host as a series of block reads, each carrying at most 32 data bytes. The management controller pushes a response into the block as a byte stream. The first beat of the stream carries a tag, and the block keeps the stream only when that tag equals the tag it expects. The host then issues command codes that pick a block: the opening block, the next block, or a retry of a block by number. Each command either fills a 33-entry staging buffer or completes with an error.

The staging buffer is filled by a copy engine that writes one message byte per cycle. While the copy runs, commands, reads and response beats are held off. The host drains the staging buffer with single-byte read requests. Each read returns the next staged byte. Once all 33 positions have been read, every further read returns 0xFF.

When a message is longer than 32 bytes, the block splits it into segments. The opening block carries a two-byte start marker. Each later block carries a sequence number, and the final block carries an end marker in place of its sequence number. SMBus bit timing and packet error checking are handled elsewhere.

Top module: `ssif_rsp_segmenter`

## Requirements
- R1: After reset the expected tag is 0, no response is held, and `cmd_ready` is 1. The staging buffer holds 33 zero bytes and the read position is 0.
- R2: A response stream is kept only if `rsp_tag` on its first beat (`rsp_first`=1) equals `exp_tag`. When it is kept, `exp_tag` increments by one. A stream whose tag differs is discarded up to and including its `rsp_last` beat, and the held message is left unchanged.
- R3: A held message of length L ≤ 32 has only block 0. Code 0x03 stages byte 0 = L and then message bytes 0..L-1 at positions 1..L.
- R4: With a message of L ≤ 32 bytes held, a request for any block other than 0 completes with `cmd_err`=1.
- R5: For L > 32, block 0 stages 32, then 0x00, then 0x01, then message bytes 0..29 at positions 3..32.
- R6: For L > 32, block n ≥ 1 starts at message offset 30+31·(n-1) and carries min(31, L-offset) bytes at positions 2 onward. Position 0 is that byte count plus 1, and position 1 is n-1 while more bytes remain after the block.
- R7: The block that contains the final message byte puts 0xFF at position 1 in place of its sequence number.
- R8: A request for a block whose start offset is at or past L completes with `cmd_err`=1.
- R9: Code 0x09 requests the block after the current block index. Code 0x0A with `cmd_has_arg`=1 requests block `cmd_arg`. Code 0x0A with `cmd_has_arg`=0 completes with `cmd_err`=1 on the cycle after acceptance.
- R10: While no response is held, any block request completes with `cmd_err`=1.
- R11: Read requests return staging positions 0, 1, 2 and onward in order. Once all 33 positions have been read, each further read returns 0xFF.
- R12: A stream longer than 255 bytes is kept as its first 255 bytes, and message byte 2 is replaced with 0xCA.
- R13: Keeping a new response sets the block index to 0 and the read position to 0, and leaves the staged bytes as they were. A successful block load also sets the read position to 0.
- R14: A failed request leaves the staged bytes and the read position unchanged. The block index still takes the requested value. Codes other than 0x03, 0x09 and 0x0A complete without error and change nothing. While a copy runs, `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | output | 1 | Response beat can be taken |
| rsp_first | input | 1 | First beat of a response; the tag is sampled on this beat |
| rsp_last | input | 1 | Last beat of a response |
| rsp_tag | input | 8 | Tag of the response |
| rsp_data | input | 8 | Response message byte |
| exp_tag | output | 8 | Tag the next response must carry |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_code | input | 8 | Command code (0x03, 0x09, 0x0A) |
| cmd_has_arg | input | 1 | Command carries a data byte |
| cmd_arg | input | 8 | Block number for a retry |
| cmd_done | output | 1 | One-cycle pulse when a command completes |
| cmd_err | output | 1 | Valid with `cmd_done`: the request failed |
| rd_req | input | 1 | Read one staged byte |
| rd_valid | output | 1 | Read data is valid (one cycle after `rd_req`) |
| rd_data | output | 8 | Staged byte, or 0xFF once all positions have been read |

## Verification
A wrong block index or a wrong segment offset shows up in the first staged bytes that the host reads back after a load. The count byte and the sequence byte in positions 0 and 1 reveal it within two reads of `cmd_done`. A read pointer that is not rewound, or that moves on an error, shifts every later byte of the read stream by one, so the scoreboard catches it on the next read. A tag or truncation fault shows up one command later: the block either stays in its error state or returns the wrong message bytes.

// File: rtl/ssif_pkg.sv
package ssif_pkg;

    localparam int LEN_W  = 8;
    localparam int DLEN_W = 6;

    localparam logic [7:0] CMD_FIRST = 8'h03;
    localparam logic [7:0] CMD_NEXT  = 8'h09;
    localparam logic [7:0] CMD_RETRY = 8'h0A;
    localparam logic [7:0] LAST_SEG  = 8'hFF;
    localparam logic [7:0] DRAINED   = 8'hFF;
    localparam logic [7:0] TRUNC_CC  = 8'hCA;

    // Description of one staged block, produced by the planner
    typedef struct packed {
        logic              ok;
        logic [7:0]        cnt;
        logic [1:0]        nhdr;
        logic [7:0]        h1;
        logic [7:0]        h2;
        logic [7:0]        src;
        logic [DLEN_W-1:0] dlen;
    } blk_desc_t;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_HDR,
        CP_DATA
    } cp_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_TAKE,
        RX_DROP
    } rx_state_e;

    function automatic logic [DLEN_W-1:0] data_pos(input logic [1:0] nhdr,
                                                   input logic [DLEN_W-1:0] idx);
        return DLEN_W'(nhdr) + DLEN_W'(1) + idx;
    endfunction

endpackage

// File: rtl/ssif_rsp_store.sv
module ssif_rsp_store
    import ssif_pkg::*;
#(
    parameter int MSG_MAX = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rsp_valid,
    input  logic             rsp_ready,
    input  logic             rsp_first,
    input  logic             rsp_last,
    input  logic [7:0]       rsp_tag,
    input  logic [7:0]       rsp_data,
    output logic [7:0]       exp_tag,
    output logic [LEN_W-1:0] held_len,
    output logic             accept_now,
    output logic             rx_busy,
    input  logic [7:0]       rd_addr,
    output logic [7:0]       rd_data
);

    localparam int             MEM_N = 1 << LEN_W;
    localparam logic [LEN_W:0] CAP   = (LEN_W+1)'(MSG_MAX);

    logic [7:0]     mem [MEM_N];
    rx_state_e      rx;
    logic [LEN_W:0] cnt, cnt_n;
    logic           ovf, ovf_n;
    logic           beat, hit, take_first, take_more, room;
    logic           wr_en, fix_en;
    logic [7:0]     wr_addr;
    logic [LEN_W-1:0] final_len;

    always_comb begin
        beat       = rsp_valid && rsp_ready;
        hit        = (rsp_tag == exp_tag);
        take_first = beat && rsp_first && hit;
        take_more  = beat && !rsp_first && (rx == RX_TAKE);
        room       = (cnt < CAP);
        wr_en      = take_first || (take_more && room);
        wr_addr    = take_first ? 8'd0 : cnt[7:0];
        if (take_first) begin
            cnt_n = (LEN_W+1)'(1);
            ovf_n = 1'b0;
        end else if (take_more && room) begin
            cnt_n = cnt + (LEN_W+1)'(1);
            ovf_n = ovf;
        end else begin
            cnt_n = cnt;
            ovf_n = ovf || (take_more && !room);
        end
        accept_now = (take_first || take_more) && rsp_last;
        fix_en     = accept_now && ovf_n;
        final_len  = ovf_n ? LEN_W'(MSG_MAX) : cnt_n[LEN_W-1:0];
    end

    assign rx_busy = (rx != RX_IDLE);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= rsp_data;
        end else if (fix_en) begin
            mem[2] <= TRUNC_CC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx       <= RX_IDLE;
            exp_tag  <= 8'd0;
            cnt      <= '0;
            ovf      <= 1'b0;
            held_len <= '0;
        end else begin
            if (beat) begin
                if (rsp_first) begin
                    if (hit) begin
                        exp_tag <= exp_tag + 8'd1;
                        rx      <= rsp_last ? RX_IDLE : RX_TAKE;
                    end else begin
                        rx      <= rsp_last ? RX_IDLE : RX_DROP;
                    end
                end else if (rsp_last) begin
                    rx <= RX_IDLE;
                end
            end
            cnt <= cnt_n;
            ovf <= ovf_n;
            if (accept_now) begin
                held_len <= final_len;
            end
        end
    end

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (exp_tag != $past(exp_tag)) |-> (exp_tag == $past(exp_tag) + 8'd1));

    // R12
    len_kept_chk: assert property (@(posedge clk) disable iff (rst)
        accept_now |=> (held_len != '0));

endmodule

// File: rtl/ssif_block_plan.sv
module ssif_block_plan
    import ssif_pkg::*;
#(
    parameter int MSG_MAX = 255,
    parameter int CHUNK   = 32
) (
    input  logic [LEN_W-1:0] held_len,
    input  logic [7:0]       blk,
    output blk_desc_t        desc
);

    localparam int FIRST_N = CHUNK - 2;
    localparam int MID_N   = CHUNK - 1;

    logic [15:0] off, rem, len16;

    always_comb begin
        desc  = '0;
        len16 = 16'(held_len);
        off   = 16'(FIRST_N) + 16'(blk - 8'd1) * 16'(MID_N);
        rem   = len16 - off;
        if (held_len == '0) begin
            desc.ok = 1'b0;
        end else if (len16 <= 16'(CHUNK)) begin
            desc.ok   = (blk == 8'd0);
            desc.cnt  = 8'(held_len);
            desc.nhdr = 2'd0;
            desc.src  = 8'd0;
            desc.dlen = DLEN_W'(held_len);
        end else if (blk == 8'd0) begin
            desc.ok   = 1'b1;
            desc.cnt  = 8'(CHUNK);
            desc.nhdr = 2'd2;
            desc.h1   = 8'h00;
            desc.h2   = 8'h01;
            desc.src  = 8'd0;
            desc.dlen = DLEN_W'(FIRST_N);
        end else begin
            desc.ok   = (off < len16);
            desc.nhdr = 2'd1;
            desc.src  = 8'(off);
            if (rem > 16'(MID_N)) begin
                desc.dlen = DLEN_W'(MID_N);
                desc.h1   = blk - 8'd1;
            end else begin
                desc.dlen = DLEN_W'(rem);
                desc.h1   = LAST_SEG;
            end
            desc.cnt = 8'(desc.dlen) + 8'd1;
        end
    end

endmodule

// File: rtl/ssif_stage_buf.sv
module ssif_stage_buf
    import ssif_pkg::*;
#(
    parameter int CHUNK = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  blk_desc_t  desc_in,
    output logic [7:0] mem_addr,
    input  logic [7:0] mem_data,
    output logic       busy,
    output logic       load_done,
    input  logic       ptr_clr,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    localparam int STG_N = CHUNK + 1;
    localparam int PW    = $clog2(STG_N + 1);

    logic [7:0]        stg [STG_N];
    cp_state_e         cp;
    blk_desc_t         d;
    logic [DLEN_W-1:0] idx, wpos;
    logic [PW-1:0]     ptr;
    logic              serve;

    assign busy     = (cp != CP_IDLE);
    assign wpos     = data_pos(d.nhdr, idx);
    assign mem_addr = d.src + 8'(idx);
    assign serve    = rd_req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cp        <= CP_IDLE;
            d         <= '0;
            idx       <= '0;
            load_done <= 1'b0;
            for (int i = 0; i < STG_N; i++) begin
                stg[i] <= 8'd0;
            end
        end else begin
            load_done <= 1'b0;
            case (cp)
                CP_IDLE: begin
                    if (load) begin
                        d  <= desc_in;
                        cp <= CP_HDR;
                    end
                end
                CP_HDR: begin
                    stg[0] <= d.cnt;
                    if (d.nhdr != 2'd0) stg[1] <= d.h1;
                    if (d.nhdr == 2'd2) stg[2] <= d.h2;
                    idx <= '0;
                    cp  <= CP_DATA;
                end
                CP_DATA: begin
                    stg[wpos] <= mem_data;
                    idx       <= idx + DLEN_W'(1);
                    if (idx == d.dlen - DLEN_W'(1)) begin
                        cp        <= CP_IDLE;
                        load_done <= 1'b1;
                    end
                end
                default: cp <= CP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= 8'd0;
        end else begin
            rd_valid <= serve;
            if (serve) begin
                rd_data <= (ptr < PW'(STG_N)) ? stg[ptr] : DRAINED;
            end
            if (load || ptr_clr) begin
                ptr <= '0;
            end else if (serve && (ptr < PW'(STG_N))) begin
                ptr <= ptr + PW'(1);
            end
        end
    end

    // R11
    drained_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && ($past(ptr) >= PW'(STG_N))) |-> (rd_data == DRAINED));

    // R11
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(STG_N));

    // R13
    load_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && (ptr == '0)));

endmodule

// File: rtl/ssif_rsp_segmenter.sv
module ssif_rsp_segmenter
    import ssif_pkg::*;
#(
    parameter int MSG_MAX = 255,
    parameter int CHUNK   = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rsp_valid,
    output logic       rsp_ready,
    input  logic       rsp_first,
    input  logic       rsp_last,
    input  logic [7:0] rsp_tag,
    input  logic [7:0] rsp_data,
    output logic [7:0] exp_tag,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_code,
    input  logic       cmd_has_arg,
    input  logic [7:0] cmd_arg,
    output logic       cmd_done,
    output logic       cmd_err,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    logic [LEN_W-1:0] held_len;
    logic             accept_now, rx_busy, stage_busy, load_done, load;
    logic [7:0]       mem_addr, mem_data, blk, tgt;
    blk_desc_t        desc;
    logic             cmd_fire, known, arg_ok, done_q, err_q;

    ssif_rsp_store #(.MSG_MAX(MSG_MAX)) store_i (
        .clk        (clk),
        .rst        (rst),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_first  (rsp_first),
        .rsp_last   (rsp_last),
        .rsp_tag    (rsp_tag),
        .rsp_data   (rsp_data),
        .exp_tag    (exp_tag),
        .held_len   (held_len),
        .accept_now (accept_now),
        .rx_busy    (rx_busy),
        .rd_addr    (mem_addr),
        .rd_data    (mem_data)
    );

    ssif_block_plan #(.MSG_MAX(MSG_MAX), .CHUNK(CHUNK)) plan_i (
        .held_len (held_len),
        .blk      (tgt),
        .desc     (desc)
    );

    ssif_stage_buf #(.CHUNK(CHUNK)) stage_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .desc_in   (desc),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .busy      (stage_busy),
        .load_done (load_done),
        .ptr_clr   (accept_now),
        .rd_req    (rd_req),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign rsp_ready = !stage_busy;
    assign cmd_ready = !stage_busy && !rx_busy && !rsp_valid;
    assign cmd_fire  = cmd_valid && cmd_ready;

    always_comb begin
        tgt    = blk;
        known  = 1'b1;
        arg_ok = 1'b1;
        case (cmd_code)
            CMD_FIRST: tgt = 8'd0;
            CMD_NEXT:  tgt = blk + 8'd1;
            CMD_RETRY: begin
                tgt    = cmd_arg;
                arg_ok = cmd_has_arg;
            end
            default:   known = 1'b0;
        endcase
    end

    assign load = cmd_fire && known && arg_ok && desc.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk    <= 8'd0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept_now) begin
                blk <= 8'd0;
            end else if (cmd_fire && known && arg_ok) begin
                blk <= tgt;
            end
            if (cmd_fire && !load) begin
                done_q <= 1'b1;
                err_q  <= known;
            end
        end
    end

    assign cmd_done = done_q || load_done;
    assign cmd_err  = err_q;

    // R9
    retry_noarg_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_fire && (cmd_code == CMD_RETRY) && !cmd_has_arg) |=> (cmd_done && cmd_err));

    // R10
    empty_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_fire && (held_len == '0) && (cmd_code == CMD_FIRST)) |=> (cmd_done && cmd_err));

    // R14
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stage_busy |-> !cmd_ready);

    // R14
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> cmd_done);

endmodule

// File: tb/ssif_rsp_segmenter_tb.sv
module ssif_rsp_segmenter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rsp_valid = 1'b0, rsp_first = 1'b0, rsp_last = 1'b0;
    logic [7:0] rsp_tag = 8'd0, rsp_data = 8'd0;
    logic       rsp_ready;
    logic [7:0] exp_tag;
    logic       cmd_valid = 1'b0, cmd_has_arg = 1'b0;
    logic [7:0] cmd_code = 8'd0, cmd_arg = 8'd0;
    logic       cmd_ready, cmd_done, cmd_err;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    ssif_rsp_segmenter dut_i (
        .clk(clk), .rst(rst),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_first(rsp_first),
        .rsp_last(rsp_last), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .exp_tag(exp_tag),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
        .cmd_has_arg(cmd_has_arg), .cmd_arg(cmd_arg),
        .cmd_done(cmd_done), .cmd_err(cmd_err),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_err = 0;

    // scoreboard
    logic [7:0] exp_q[$];
    string      req_q[$];

    // reference model state
    logic [7:0] m_msg [256];
    logic [7:0] m_stg [33];
    int         m_len = 0;
    int         m_ptr = 0;
    int         m_blk = 0;
    logic [7:0] m_tag = 8'd0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_load(input int b);
        int off, n;
        if (m_len == 0) return 1'b0;
        if (m_len <= 32) begin
            if (b != 0) return 1'b0;
            m_stg[0] = 8'(m_len);
            for (int i = 0; i < m_len; i++) m_stg[1+i] = m_msg[i];
        end else if (b == 0) begin
            m_stg[0] = 8'd32;
            m_stg[1] = 8'h00;
            m_stg[2] = 8'h01;
            for (int i = 0; i < 30; i++) m_stg[3+i] = m_msg[i];
        end else begin
            off = 30 + (b - 1) * 31;
            if (off >= m_len) return 1'b0;
            if (m_len - off > 31) begin
                n = 31;
                m_stg[1] = 8'(b - 1);
            end else begin
                n = m_len - off;
                m_stg[1] = 8'hFF;
            end
            m_stg[0] = 8'(n + 1);
            for (int i = 0; i < n; i++) m_stg[2+i] = m_msg[off+i];
        end
        m_ptr = 0;
        return 1'b1;
    endfunction

    task automatic send_rsp(input logic [7:0] tag, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_first = (i == 0);
            rsp_last  = (i == n - 1);
            rsp_tag   = tag;
            rsp_data  = 8'((i * 7 + seed) & 255);
            while (!rsp_ready) @(negedge clk);
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_first = 1'b0;
        rsp_last  = 1'b0;
        if (tag == m_tag) begin
            m_tag = m_tag + 8'd1;
            m_len = (n > 255) ? 255 : n;
            for (int i = 0; i < m_len; i++) m_msg[i] = 8'((i * 7 + seed) & 255);
            if (n > 255) m_msg[2] = 8'hCA;
            m_ptr = 0;
            m_blk = 0;
        end
        check(exp_tag == m_tag, "R2", "exp_tag after response", exp_tag, m_tag);
    endtask

    task automatic do_cmd(input logic [7:0] code, input bit has_arg,
                          input logic [7:0] arg, input string req);
        bit known, arg_ok, want_err;
        int tgt, guard;
        known  = 1'b1;
        arg_ok = 1'b1;
        tgt    = m_blk;
        case (code)
            8'h03: tgt = 0;
            8'h09: tgt = (m_blk + 1) & 255;
            8'h0A: begin
                tgt    = arg;
                arg_ok = has_arg;
            end
            default: known = 1'b0;
        endcase
        want_err = 1'b0;
        if (known) begin
            if (!arg_ok) want_err = 1'b1;
            else begin
                m_blk = tgt;
                want_err = !model_load(tgt);
            end
        end
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_code    = code;
        cmd_has_arg = has_arg;
        cmd_arg     = arg;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!cmd_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(cmd_done == 1'b1, req, "command completion", cmd_done, 1);
        check(cmd_err == want_err, req, "command error flag", cmd_err, want_err);
    endtask

    task automatic read_n(input int k, input string req);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            rd_req = 1'b1;
            if (m_ptr < 33) begin
                exp_q.push_back(m_stg[m_ptr]);
                m_ptr++;
            end else begin
                exp_q.push_back(8'hFF);
            end
            req_q.push_back(req);
        end
        @(negedge clk);
        rd_req = 1'b0;
        for (int w = 0; w < 10 && exp_q.size() != 0; w++) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected read data", rd_data, 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(rd_data == e, r, "read byte", rd_data, e);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 33; i++) m_stg[i] = 8'd0;
        for (int i = 0; i < 256; i++) m_msg[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(exp_tag == 8'd0, "R1", "exp_tag at reset", exp_tag, 0);
        check(cmd_ready == 1'b1, "R1", "cmd_ready at reset", cmd_ready, 1);
        check(cmd_done == 1'b0, "R1", "cmd_done at reset", cmd_done, 0);
        read_n(34, "R1");
        // R10 empty, R9 retry without argument
        do_cmd(8'h03, 1'b0, 8'd0, "R10");
        do_cmd(8'h0A, 1'b0, 8'd0, "R9");
        // R2 wrong tag discarded
        send_rsp(8'd5, 6, 1);
        do_cmd(8'h03, 1'b0, 8'd0, "R2");
        // short message
        send_rsp(8'd0, 10, 3);
        do_cmd(8'h03, 1'b0, 8'd0, "R3");
        read_n(5, "R3");
        do_cmd(8'h09, 1'b0, 8'd0, "R4");
        read_n(29, "R14");
        do_cmd(8'h55, 1'b0, 8'd0, "R14");
        read_n(2, "R11");
        // long message of 100 bytes
        send_rsp(8'd1, 100, 11);
        do_cmd(8'h09, 1'b0, 8'd0, "R13");
        read_n(34, "R6");
        do_cmd(8'h03, 1'b0, 8'd0, "R5");
        read_n(34, "R5");
        do_cmd(8'h09, 1'b0, 8'd0, "R6");
        do_cmd(8'h09, 1'b0, 8'd0, "R6");
        read_n(34, "R6");
        do_cmd(8'h09, 1'b0, 8'd0, "R7");
        read_n(34, "R7");
        do_cmd(8'h09, 1'b0, 8'd0, "R8");
        read_n(1, "R14");
        do_cmd(8'h0A, 1'b1, 8'd2, "R9");
        read_n(4, "R9");
        // oversized stream rewinds read position, stale bytes kept
        send_rsp(8'd2, 300, 20);
        read_n(34, "R13");
        do_cmd(8'h03, 1'b0, 8'd0, "R12");
        read_n(34, "R12");
        do_cmd(8'h0A, 1'b1, 8'd8, "R7");
        read_n(34, "R7");
        do_cmd(8'h0A, 1'b1, 8'd7, "R6");
        read_n(34, "R6");
        do_cmd(8'h0A, 1'b1, 8'd9, "R8");
        do_cmd(8'h0A, 1'b0, 8'd3, "R9");
        // wrong tag leaves held message
        send_rsp(8'h77, 5, 40);
        do_cmd(8'h03, 1'b0, 8'd0, "R2");
        read_n(10, "R2");
        // boundary lengths
        send_rsp(8'd3, 32, 50);
        do_cmd(8'h03, 1'b0, 8'd0, "R3");
        read_n(34, "R3");
        do_cmd(8'h0A, 1'b1, 8'd1, "R4");
        send_rsp(8'd4, 33, 60);
        do_cmd(8'h03, 1'b0, 8'd0, "R5");
        read_n(34, "R5");
        do_cmd(8'h09, 1'b0, 8'd0, "R7");
        read_n(34, "R7");
        do_cmd(8'h09, 1'b0, 8'd0, "R8");
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule